// File: doc/BRIEF.md
# CPU and DMA Shared Bus Arbiter

This block settles ownership of a shared memory bus between the processor and a DMA engine. On every clock edge it samples a CPU request, a DMA request and the 2-bit priority code of the currently active DMA channel. It then drives registered grant outputs for the following cycle. When only one side asks, that side is served. When both ask, the priority code decides.

Code 00 always favours the CPU. Codes 10 and 11 always favour the DMA. Code 11 is the level kept for the DMA's direct port access path. Code 01 is the guaranteed level. A one-bit history records that the DMA lost a contest at that level, so that the DMA wins the next contest. Under steady contention the DMA is therefore served on at least every second attempt.

The block is placed between the request sources and the bus multiplexer. The grant outputs steer that multiplexer directly.

Top module: `cpu_dma_arb`

## Requirements
- R1: A synchronous active-high reset drives both grants and the grant-valid strobe low and clears the loss history. After reset, the first contest at code 01 goes to the CPU.
- R2: When exactly one side requests, that side is granted on the next cycle, whatever the priority code.
- R3: When neither side requests, neither grant is driven and the grant-valid strobe is low on the next cycle.
- R4: Code 00 (low): in a contest, where both request, the CPU is granted.
- R5: Code 10 (high): in a contest, the DMA is granted.
- R6: Code 11 (top, for the port access path): in a contest, the DMA is granted.
- R7: Code 01 (guaranteed): a contest with the loss history clear goes to the CPU and sets the history. A contest with the history set goes to the DMA and clears it. Back-to-back contests therefore alternate CPU, DMA, CPU, DMA.
- R8: The loss history is cleared in any cycle where the DMA request is low, and in any cycle where the DMA is granted.
- R9: At most one grant is high in any cycle. The grant-valid strobe is high exactly when one grant is high.
- R10: Grants are registered. Inputs sampled at a clock edge affect the outputs only after that edge, and the outputs do not change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor wants the bus |
| dma_req | input | 1 | DMA engine wants the bus |
| dma_prio | input | 2 | Priority code of the active DMA channel: 00 low, 01 guaranteed, 10 high, 11 top |
| cpu_gnt | output | 1 | Registered bus grant to the processor |
| dma_gnt | output | 1 | Registered bus grant to the DMA engine |
| gnt_vld | output | 1 | Registered strobe, high when a grant is issued |

## Verification
Every grant result is due exactly one clock edge after the requests and code that produced it are sampled. The loss history updates at that same edge, so it shapes only the decision made at the next edge.

The bench drives inputs on the falling edge and samples the outputs 1 ns after the following rising edge, which is the first point where the result is valid. To cover R10, it also samples just after the falling edge where inputs change, and confirms that the outputs still show the previous decision.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int PRIO_W = 2;

  typedef enum logic [PRIO_W-1:0] {
    PRIO_LOW  = 2'b00,
    PRIO_GUAR = 2'b01,
    PRIO_HIGH = 2'b10,
    PRIO_TOP  = 2'b11
  } prio_e;
endpackage

// File: rtl/arb_pick.sv
module arb_pick
  import arb_pkg::*;
(
  input  logic              cpu_req,
  input  logic              dma_req,
  input  logic [PRIO_W-1:0] dma_prio,
  input  logic              lost_q,
  output logic              cpu_win,
  output logic              dma_win,
  output logic              lost_set
);
  logic  contest;
  prio_e level;

  assign contest = cpu_req & dma_req;
  assign level   = prio_e'(dma_prio);

  always_comb begin
    cpu_win  = cpu_req & ~dma_req;
    dma_win  = dma_req & ~cpu_req;
    lost_set = 1'b0;
    if (contest) begin
      unique case (level)
        PRIO_LOW:  cpu_win = 1'b1;
        PRIO_GUAR: begin
          dma_win  = lost_q;
          cpu_win  = ~lost_q;
          lost_set = ~lost_q;
        end
        PRIO_HIGH: dma_win = 1'b1;
        PRIO_TOP:  dma_win = 1'b1;
        default:   cpu_win = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/arb_loss_flag.sv
module arb_loss_flag (
  input  logic clk,
  input  logic rst,
  input  logic dma_req,
  input  logic lost_set,
  input  logic dma_won,
  output logic lost_q
);
  always_ff @(posedge clk) begin
    if (rst || !dma_req || dma_won) lost_q <= 1'b0;
    else if (lost_set)              lost_q <= 1'b1;
  end
endmodule

// File: rtl/cpu_dma_arb.sv
module cpu_dma_arb
  import arb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              dma_req,
  input  logic [PRIO_W-1:0] dma_prio,
  output logic              cpu_gnt,
  output logic              dma_gnt,
  output logic              gnt_vld
);
  logic cpu_win, dma_win, lost_set, lost_q;

  arb_pick pick_i (
    .cpu_req  (cpu_req),
    .dma_req  (dma_req),
    .dma_prio (dma_prio),
    .lost_q   (lost_q),
    .cpu_win  (cpu_win),
    .dma_win  (dma_win),
    .lost_set (lost_set)
  );

  arb_loss_flag hist_i (
    .clk      (clk),
    .rst      (rst),
    .dma_req  (dma_req),
    .lost_set (lost_set),
    .dma_won  (dma_win),
    .lost_q   (lost_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_gnt <= 1'b0;
      dma_gnt <= 1'b0;
      gnt_vld <= 1'b0;
    end else begin
      cpu_gnt <= cpu_win;
      dma_gnt <= dma_win;
      gnt_vld <= cpu_win | dma_win;
    end
  end
endmodule

// File: rtl/arb_checker.sv
module arb_checker (
  input logic       clk,
  input logic       rst,
  input logic       cpu_req,
  input logic       dma_req,
  input logic [1:0] dma_prio,
  input logic       cpu_gnt,
  input logic       dma_gnt,
  input logic       gnt_vld
);
  logic both;
  assign both = cpu_req & dma_req;

  a_r9_one_grant: assert property (@(posedge clk) disable iff (rst)
    !(cpu_gnt && dma_gnt));
  a_r9_vld_match: assert property (@(posedge clk) disable iff (rst)
    gnt_vld == (cpu_gnt || dma_gnt));
  a_r2_cpu_alone: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && !dma_req) |=> cpu_gnt);
  a_r2_dma_alone: assert property (@(posedge clk) disable iff (rst)
    (dma_req && !cpu_req) |=> dma_gnt);
  a_r3_idle: assert property (@(posedge clk) disable iff (rst)
    (!cpu_req && !dma_req) |=> !gnt_vld);
  a_r4_low_cpu: assert property (@(posedge clk) disable iff (rst)
    (both && dma_prio == 2'b00) |=> cpu_gnt);
  a_r5_high_dma: assert property (@(posedge clk) disable iff (rst)
    (both && dma_prio == 2'b10) |=> dma_gnt);
  a_r6_top_dma: assert property (@(posedge clk) disable iff (rst)
    (both && dma_prio == 2'b11) |=> dma_gnt);
  a_r7_guarantee: assert property (@(posedge clk) disable iff (rst)
    (both && dma_prio == 2'b01) ##1 (both && dma_prio == 2'b01 && cpu_gnt) |=> dma_gnt);
endmodule

bind cpu_dma_arb arb_checker chk_i (
  .clk      (clk),
  .rst      (rst),
  .cpu_req  (cpu_req),
  .dma_req  (dma_req),
  .dma_prio (dma_prio),
  .cpu_gnt  (cpu_gnt),
  .dma_gnt  (dma_gnt),
  .gnt_vld  (gnt_vld)
);

// File: tb/cpu_dma_arb_tb_top.sv
module cpu_dma_arb_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cpu_req = 1'b0;
  logic       dma_req = 1'b0;
  logic [1:0] dma_prio = 2'b00;
  logic       cpu_gnt, dma_gnt, gnt_vld;
  int         n_chk = 0;
  int         n_err = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  cpu_dma_arb dut_i (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .dma_req(dma_req),
    .dma_prio(dma_prio), .cpu_gnt(cpu_gnt), .dma_gnt(dma_gnt), .gnt_vld(gnt_vld)
  );

  task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: {cpu_gnt,dma_gnt,gnt_vld} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Drive inputs at the falling edge, sample 1 ns after the next rising edge.
  task automatic step(input logic c, input logic d, input logic [1:0] p,
                      input logic ec, input logic ed, input string tag);
    @(negedge clk);
    cpu_req = c; dma_req = d; dma_prio = p;
    @(posedge clk); #1;
    chk(tag, {cpu_gnt, dma_gnt, gnt_vld}, {ec, ed, ec | ed});
    if (cpu_gnt && dma_gnt) chk("R9 both grants", 3'b110, 3'b000);
  endtask

  task automatic t_reset;
    @(negedge clk); rst = 1'b1; cpu_req = 1'b1; dma_req = 1'b1;
    @(posedge clk); #1;
    chk("R1 reset state", {cpu_gnt, dma_gnt, gnt_vld}, 3'b000);
    @(negedge clk); rst = 1'b0; cpu_req = 1'b0; dma_req = 1'b0;
  endtask

  task automatic t_idle;
    step(0, 0, 2'b11, 0, 0, "R3 idle");
    step(0, 0, 2'b00, 0, 0, "R3 idle");
  endtask

  task automatic t_single;
    for (int p = 0; p < 4; p++) step(1, 0, 2'(p), 1, 0, "R2 cpu alone");
    for (int p = 0; p < 4; p++) step(0, 1, 2'(p), 0, 1, "R2 dma alone");
  endtask

  task automatic t_levels;
    step(1, 1, 2'b00, 1, 0, "R4 low contest");
    step(1, 1, 2'b00, 1, 0, "R4 low contest");
    step(1, 1, 2'b10, 0, 1, "R5 high contest");
    step(1, 1, 2'b11, 0, 1, "R6 top contest");
  endtask

  task automatic t_guar;
    step(1, 0, 2'b01, 1, 0, "R8 clear history");
    step(1, 1, 2'b01, 1, 0, "R7 first contest cpu");
    step(1, 1, 2'b01, 0, 1, "R7 second contest dma");
    step(1, 1, 2'b01, 1, 0, "R7 third contest cpu");
    step(1, 1, 2'b01, 0, 1, "R7 fourth contest dma");
  endtask

  task automatic t_drop;
    step(1, 1, 2'b01, 1, 0, "R7 contest cpu");
    step(1, 0, 2'b01, 1, 0, "R8 dma drops");
    step(1, 1, 2'b01, 1, 0, "R8 history cleared by drop");
    step(0, 1, 2'b01, 0, 1, "R8 dma alone granted");
    step(1, 1, 2'b01, 1, 0, "R8 history cleared by dma grant");
  endtask

  task automatic t_latency;
    step(1, 1, 2'b00, 1, 0, "R10 setup");
    @(negedge clk);
    cpu_req = 1'b0; dma_req = 1'b1; dma_prio = 2'b10;
    #1;
    chk("R10 holds until edge", {cpu_gnt, dma_gnt, gnt_vld}, 3'b101);
    @(posedge clk); #1;
    chk("R10 after edge", {cpu_gnt, dma_gnt, gnt_vld}, 3'b011);
  endtask

  task automatic t_reset_mid;
    step(1, 1, 2'b01, 1, 0, "R7 sets history");
    t_reset;
    step(1, 1, 2'b01, 1, 0, "R1 history cleared by reset");
  endtask

  initial begin
    repeat (2) @(posedge clk);
    t_reset;
    t_idle;
    t_single;
    t_levels;
    t_guar;
    t_drop;
    t_latency;
    t_reset_mid;
    step(0, 0, 2'b00, 0, 0, "R3 final idle");
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule